// File: doc/BRIEF.md
# ECC Error Logging Register Unit

This unit sits beside a memory controller's error-correction datapath and records DRAM error events for software. The datapath raises a one-cycle pulse for a correctable error or for an uncorrectable error. Each pulse comes with the 33-bit physical address of the failing access, the channel it used and the 8-bit ECC syndrome. Three more event pulses report a thermal sensor trip, a locked access that targeted non-DRAM memory, and a refresh timeout.

Every event sets a flag in a 16-bit status register, and software clears a flag by writing 1 to it. Only one failing address, channel and syndrome is logged at a time. An uncorrectable error replaces a logged correctable one. A correctable error never disturbs a log that is already pending. A 16-bit command register uses the same bit positions as the status register and selects which flags drive the level-sensitive system-error output.

Software reaches the registers through a synchronous port with a 3-bit register select, a 16-bit write bus with two byte enables, and a 32-bit read bus. Read data appears one cycle after the read request.

Top module: `eccErrLog`

## Requirements
- R1: After reset, every register reads zero and `sysErr` is low.
- R2: The status register sits at select 0. A correctable pulse sets bit 0 and an uncorrectable pulse sets bit 1. A refresh timeout sets bit 8, a locked non-DRAM access sets bit 9 and a thermal trip sets bit 11. All other bits read zero, so the implemented-bit mask is 0x0B03.
- R3: A status write clears each implemented bit that has a 1 in an enabled byte. Bits written 0, and bits in disabled bytes, keep their value. An event that arrives in the same cycle as a clear of its bit leaves the bit set.
- R4: The register selects are 0 status, 1 command, 2 error address, 3 extended address and 4 syndrome. Selects 5 to 7 read zero. `rdData` takes the selected value on the clock edge that samples `regRdEn` high and holds it otherwise.
- R5: The error address register holds physical address bits 31:7 in bits 31:7, zeros in bits 6:1 and the channel in bit 0. The extended address register holds address bit 32 in bit 0 and zeros in bits 31:1.
- R6: A correctable pulse that arrives while status bits 0 and 1 are both clear logs its address, channel and syndrome.
- R7: An uncorrectable pulse that arrives while status bit 1 is clear logs its information, replacing any logged correctable error. An uncorrectable pulse that arrives while bit 1 is already set keeps the first log.
- R8: A correctable pulse that arrives while status bit 0 or bit 1 is set changes no log register. It only sets status bit 0.
- R9: When correctable and uncorrectable pulses arrive in the same cycle, both flags set and the uncorrectable error is logged.
- R10: The command register at select 1 is written byte by byte under the byte enables and stores only bits 0, 1, 8, 9 and 11. Its other bits read zero.
- R11: `sysErr` is high exactly when some status bit and the command bit at the same position are both set. It falls once software clears the enabled status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceValid | input | 1 | Correctable ECC error pulse |
| ueValid | input | 1 | Uncorrectable ECC error pulse |
| errAddr | input | 33 | Physical address of the failing access |
| errChan | input | 1 | Channel of the failing access |
| errSyn | input | 8 | ECC syndrome of the failing access |
| thermTrip | input | 1 | Thermal sensor event pulse |
| lockNonDram | input | 1 | Locked access to non-DRAM memory pulse |
| refreshTimeout | input | 1 | Refresh timeout pulse |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regSel | input | 3 | Register select |
| wrData | input | 16 | Write data |
| wrBe | input | 2 | Write byte enables |
| rdData | output | 32 | Read data, one cycle after `regRdEn` |
| sysErr | output | 1 | System-error level |

## Verification
The bench sends a correctable error, then a second correctable error with a different address. A design that re-logged on every correctable pulse would show the second address. It then sends an uncorrectable error and a second uncorrectable one. A design that failed to let the uncorrectable error replace the correctable log, or that let the second one replace the first, would return the wrong syndrome and address. Status clears are tested with zero bits, with a disabled byte and against an event in the same cycle. Designs with a clear that ignores the byte enables, or a clear that beats the event, read back the wrong flags. The bench also drives `sysErr` with events that the command register masks and with events it enables, which catches a design that ignores the command gate or keeps `sysErr` high after the clear.

// File: rtl/eccLogPkg.sv
package eccLogPkg;
  localparam int ADDR_W    = 33;
  localparam int GRAIN_LSB = 7;
  localparam int SYN_W     = 8;
  localparam int REG_W     = 16;
  localparam int RD_W      = 32;
  localparam int SEL_W     = 3;
  localparam int BE_W      = REG_W / 8;
  localparam int LOW_W     = RD_W - GRAIN_LSB;

  localparam int BIT_CE    = 0;
  localparam int BIT_UE    = 1;
  localparam int BIT_REFTO = 8;
  localparam int BIT_LOCK  = 9;
  localparam int BIT_THERM = 11;

  localparam logic [REG_W-1:0] IMPL_MASK = REG_W'((1 << BIT_CE) | (1 << BIT_UE) |
    (1 << BIT_REFTO) | (1 << BIT_LOCK) | (1 << BIT_THERM));

  localparam logic [SEL_W-1:0] SEL_STATUS = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CMD    = 3'd1;
  localparam logic [SEL_W-1:0] SEL_ADDR   = 3'd2;
  localparam logic [SEL_W-1:0] SEL_EXT    = 3'd3;
  localparam logic [SEL_W-1:0] SEL_SYN    = 3'd4;

  typedef struct packed {
    logic capture;
    logic rdLatch;
  } ctrlStrobe_t;
endpackage

// File: rtl/eccLogCtrl.sv
module eccLogCtrl
  import eccLogPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceValid,
  input  logic              ueValid,
  input  logic              thermTrip,
  input  logic              lockNonDram,
  input  logic              refreshTimeout,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [REG_W-1:0]  wrData,
  input  logic [BE_W-1:0]   wrBe,
  output logic [REG_W-1:0]  statusQ,
  output logic [REG_W-1:0]  cmdQ,
  output ctrlStrobe_t       strobe,
  output logic              sysErr
);
  logic [REG_W-1:0] setBits;
  logic [REG_W-1:0] clrBits;
  logic [REG_W-1:0] beMask;
  logic             eccPending;

  always_comb begin
    for (int b = 0; b < BE_W; b++) beMask[b*8 +: 8] = {8{wrBe[b]}};
  end

  always_comb begin
    setBits = '0;
    setBits[BIT_CE]    = ceValid;
    setBits[BIT_UE]    = ueValid;
    setBits[BIT_REFTO] = refreshTimeout;
    setBits[BIT_LOCK]  = lockNonDram;
    setBits[BIT_THERM] = thermTrip;
  end

  assign clrBits    = (regWrEn && regSel == SEL_STATUS) ? (wrData & beMask) : '0;
  assign eccPending = statusQ[BIT_CE] | statusQ[BIT_UE];

  always_comb begin
    strobe.capture = (ueValid && !statusQ[BIT_UE]) || (ceValid && !eccPending);
    strobe.rdLatch = regRdEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      statusQ <= ((statusQ & ~clrBits) | setBits) & IMPL_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ <= '0;
    end else if (regWrEn && regSel == SEL_CMD) begin
      cmdQ <= ((cmdQ & ~beMask) | (wrData & beMask)) & IMPL_MASK;
    end
  end

  assign sysErr = |(statusQ & cmdQ);

  AST_UE_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    ueValid |=> statusQ[BIT_UE]); // R2

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == SEL_STATUS && wrBe[0] && wrData[BIT_CE] && !ceValid)
      |=> !statusQ[BIT_CE]); // R3

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ceValid |=> statusQ[BIT_CE]); // R3

  AST_SYSERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    sysErr |-> (statusQ != '0 && cmdQ != '0)); // R11
endmodule

// File: rtl/eccLogData.sv
module eccLogData
  import eccLogPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic              errChan,
  input  logic [SYN_W-1:0]  errSyn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [REG_W-1:0]  statusQ,
  input  logic [REG_W-1:0]  cmdQ,
  output logic [RD_W-1:0]   rdData
);
  logic [LOW_W-1:0] addrLoQ;
  logic             addrHiQ;
  logic             chanQ;
  logic [SYN_W-1:0] synQ;
  logic [RD_W-1:0]  rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLoQ <= '0;
      addrHiQ <= 1'b0;
      chanQ   <= 1'b0;
      synQ    <= '0;
    end else if (strobe.capture) begin
      addrLoQ <= errAddr[RD_W-1:GRAIN_LSB];
      addrHiQ <= errAddr[ADDR_W-1];
      chanQ   <= errChan;
      synQ    <= errSyn;
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (regSel)
      SEL_STATUS: rdNext = {{(RD_W-REG_W){1'b0}}, statusQ};
      SEL_CMD:    rdNext = {{(RD_W-REG_W){1'b0}}, cmdQ};
      SEL_ADDR:   rdNext = {addrLoQ, {(GRAIN_LSB-1){1'b0}}, chanQ};
      SEL_EXT:    rdNext = {{(RD_W-1){1'b0}}, addrHiQ};
      SEL_SYN:    rdNext = {{(RD_W-SYN_W){1'b0}}, synQ};
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.rdLatch) begin
      rdData <= rdNext;
    end
  end

  AST_CAPTURE_SYN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> synQ == $past(errSyn)); // R6

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdLatch |=> $stable(rdData)); // R4
endmodule

// File: rtl/eccErrLog.sv
module eccErrLog
  import eccLogPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceValid,
  input  logic              ueValid,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic              errChan,
  input  logic [SYN_W-1:0]  errSyn,
  input  logic              thermTrip,
  input  logic              lockNonDram,
  input  logic              refreshTimeout,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [REG_W-1:0]  wrData,
  input  logic [BE_W-1:0]   wrBe,
  output logic [RD_W-1:0]   rdData,
  output logic              sysErr
);
  logic [REG_W-1:0] statusQ;
  logic [REG_W-1:0] cmdQ;
  ctrlStrobe_t      strobe;

  eccLogCtrl uCtrl (
    .clk(clk), .rstN(rstN), .ceValid(ceValid), .ueValid(ueValid),
    .thermTrip(thermTrip), .lockNonDram(lockNonDram), .refreshTimeout(refreshTimeout),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regSel(regSel), .wrData(wrData), .wrBe(wrBe),
    .statusQ(statusQ), .cmdQ(cmdQ), .strobe(strobe), .sysErr(sysErr)
  );

  eccLogData uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .errAddr(errAddr), .errChan(errChan),
    .errSyn(errSyn), .regSel(regSel), .statusQ(statusQ), .cmdQ(cmdQ), .rdData(rdData)
  );

  AST_CE_KEEPS_LOG: assert property (@(posedge clk) disable iff (!rstN)
    (ceValid && !ueValid && (statusQ[BIT_CE] || statusQ[BIT_UE])) |=> $stable(uData.synQ)); // R8

  AST_UE_OVERWRITES: assert property (@(posedge clk) disable iff (!rstN)
    (ueValid && !statusQ[BIT_UE]) |=> uData.synQ == $past(errSyn)); // R7
endmodule

// File: tb/eccErrLog_test.sv
`timescale 1ns/1ps
module eccErrLog_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceValid = 0, ueValid = 0, thermTrip = 0, lockNonDram = 0, refreshTimeout = 0;
  logic [32:0] errAddr = '0;
  logic        errChan = 0;
  logic [7:0]  errSyn = '0;
  logic        regWrEn = 0, regRdEn = 0;
  logic [2:0]  regSel = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  wrBe = '0;
  logic [31:0] rdData;
  logic        sysErr;
  int          testCount = 0;
  int          failCount = 0;

  always #4 clk = ~clk;

  eccErrLog uut (
    .clk(clk), .rstN(rstN), .ceValid(ceValid), .ueValid(ueValid), .errAddr(errAddr),
    .errChan(errChan), .errSyn(errSyn), .thermTrip(thermTrip), .lockNonDram(lockNonDram),
    .refreshTimeout(refreshTimeout), .regWrEn(regWrEn), .regRdEn(regRdEn), .regSel(regSel),
    .wrData(wrData), .wrBe(wrBe), .rdData(rdData), .sysErr(sysErr)
  );

  // {ce, ue, refresh, lock, thermal, expected status}
  localparam logic [20:0] VEC [8] = '{
    {5'b10000, 16'h0001}, {5'b01000, 16'h0002}, {5'b00100, 16'h0100},
    {5'b00010, 16'h0200}, {5'b00001, 16'h0800}, {5'b11000, 16'h0003},
    {5'b00111, 16'h0B00}, {5'b11111, 16'h0B03}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [2:0] sel, output logic [31:0] val);
    @(negedge clk); regRdEn = 1; regSel = sel;
    @(negedge clk); regRdEn = 0; val = rdData;
  endtask

  task automatic writeReg(input logic [2:0] sel, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk); regWrEn = 1; regSel = sel; wrData = d; wrBe = be;
    @(negedge clk); regWrEn = 0; wrBe = 0;
  endtask

  task automatic pulse(input logic [4:0] evt, input logic [32:0] a, input logic ch,
                       input logic [7:0] s);
    @(negedge clk);
    {ceValid, ueValid, refreshTimeout, lockNonDram, thermTrip} = evt;
    errAddr = a; errChan = ch; errSyn = s;
    @(negedge clk);
    {ceValid, ueValid, refreshTimeout, lockNonDram, thermTrip} = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    check("R1 sysErr after reset", {31'b0, sysErr}, 32'h0);
    for (int s = 0; s < 8; s++) begin
      readReg(s[2:0], v);
      check("R1/R4 register zero after reset", v, 32'h0);
    end

    for (int i = 0; i < 8; i++) begin
      writeReg(3'd0, 16'hFFFF, 2'b11);
      pulse(VEC[i][20:16], 33'h0_0000_0080, 1'b0, 8'h01);
      readReg(3'd0, v);
      check("R2 status flag pattern", v, {16'h0, VEC[i][15:0]});
    end
    writeReg(3'd0, 16'hFFFF, 2'b11);
    readReg(3'd0, v);
    check("R3 clear all", v, 32'h0);

    pulse(5'b10000, 33'h1_2345_67FF, 1'b1, 8'h3C);
    readReg(3'd2, v); check("R5/R6 error address", v, 32'h2345_6781);
    readReg(3'd3, v); check("R5 extended address", v, 32'h1);
    readReg(3'd4, v); check("R6 syndrome", v, 32'h3C);

    pulse(5'b10000, 33'h0_89AB_CD80, 1'b0, 8'h5A);
    readReg(3'd2, v); check("R8 address kept", v, 32'h2345_6781);
    readReg(3'd4, v); check("R8 syndrome kept", v, 32'h3C);

    pulse(5'b01000, 33'h0_89AB_CD80, 1'b0, 8'h5A);
    readReg(3'd2, v); check("R7 address overwritten", v, 32'h89AB_CD80);
    readReg(3'd3, v); check("R7 extended overwritten", v, 32'h0);
    readReg(3'd4, v); check("R7 syndrome overwritten", v, 32'h5A);
    readReg(3'd0, v); check("R7 both flags", v, 32'h3);

    pulse(5'b01000, 33'h1_2345_67FF, 1'b1, 8'h11);
    readReg(3'd4, v); check("R7 first UE log kept", v, 32'h5A);

    writeReg(3'd0, 16'h0002, 2'b01);
    readReg(3'd0, v); check("R3 zero bits unchanged", v, 32'h1);
    writeReg(3'd0, 16'h0001, 2'b10);
    readReg(3'd0, v); check("R3 disabled byte ignored", v, 32'h1);
    @(negedge clk); regWrEn = 1; regSel = 3'd0; wrData = 16'h0001; wrBe = 2'b01; ceValid = 1;
    @(negedge clk); regWrEn = 0; wrBe = 0; ceValid = 0;
    readReg(3'd0, v); check("R3 event wins over clear", v, 32'h1);
    writeReg(3'd0, 16'hFFFF, 2'b11);

    pulse(5'b11000, 33'h0_0F0F_0F00, 1'b1, 8'hA7);
    readReg(3'd0, v); check("R9 both flags", v, 32'h3);
    readReg(3'd4, v); check("R9 syndrome logged", v, 32'hA7);
    readReg(3'd2, v); check("R9 address logged", v, 32'h0F0F_0F01);

    writeReg(3'd1, 16'hFFFF, 2'b01);
    readReg(3'd1, v); check("R10 low byte only", v, 32'h0003);
    writeReg(3'd1, 16'hFFFF, 2'b11);
    readReg(3'd1, v); check("R10 implemented bits", v, 32'h0B03);
    readReg(3'd6, v); check("R4 unmapped select", v, 32'h0);

    writeReg(3'd1, 16'h0002, 2'b11);
    writeReg(3'd0, 16'hFFFF, 2'b11);
    check("R11 low after clear", {31'b0, sysErr}, 32'h0);
    pulse(5'b10000, 33'h0, 1'b0, 8'h00);
    check("R11 masked event", {31'b0, sysErr}, 32'h0);
    pulse(5'b01000, 33'h0, 1'b0, 8'h00);
    check("R11 enabled event", {31'b0, sysErr}, 32'h1);
    writeReg(3'd0, 16'h0002, 2'b01);
    check("R11 falls after clear", {31'b0, sysErr}, 32'h0);
    writeReg(3'd1, 16'h0100, 2'b10);
    pulse(5'b00100, 33'h0, 1'b0, 8'h00);
    check("R11 refresh timeout enabled", {31'b0, sysErr}, 32'h1);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule